// File: doc/BRIEF.md
# Block-Ack Receive Reorder Buffer

This block restores sequence order for aggregated data frames of a single traffic stream. Each arriving frame is presented as a 12-bit sequence number together with a buffer handle. Frames that arrive early are parked in a small circular slot array. Their handles are released upstream as soon as the gap in front of them closes. The block never touches frame payloads. It keeps only a handle and an arrival timestamp per slot.

Control comes from three sources. Session setup provides a start sequence and window sizes, and can request a sequence resynchronisation. Block-ack-request commands move the receive window forward. A periodic timeout tick releases frames that have waited too long. Released handles leave one per cycle on a valid/ready stream. Old and duplicate frames are reported by one-cycle pulses. While any command is being worked off, new commands are held off.

Top module: `ba_reorder_buf`

## Requirements
- R1: While `agg_en_i` is low, every accepted frame is released unchanged on the release stream without buffering, in arrival order, whatever its sequence number.
- R2: A frame whose sequence equals the expected sequence is released at once. Each in-order release advances the expected sequence by one, modulo 4096.
- R3: A frame whose relative index (arriving sequence minus expected, modulo 4096) is below the window is held. It is released in sequence order once all earlier slots are filled, and release stops at the first empty slot.
- R4: A frame with relative index greater than 4096 minus four times the effective window is discarded. `drop_o` pulses for one cycle and nothing is released.
- R5: A frame that maps to a slot already holding a handle is discarded, `dup_o` pulses for one cycle, and the held handle is kept.
- R6: A frame with relative index at or beyond the window first advances the head. Held frames are released and empty slots are skipped, one step per cycle, until the index falls inside the window. The frame is then stored and in-order release follows.
- R7: After a pulse on `seq_rst_i`, the next buffered frame sets the expected sequence to its own sequence, so it is released at once.
- R8: A block-ack request releases held frames and skips empty slots from the head up to its sequence, then releases any further in-order frames. With an empty buffer it sets the expected sequence to its own sequence. It is discarded with a `drop_o` pulse when its index exceeds both the window and the old-frame limit, or when `agg_en_i` is low.
- R9: A timeout tick skips empty head slots and releases held frames whose age is at least `TMO_CYC` cycles. It stops at the first held frame that is younger.
- R10: The effective window is the smaller of `win_cfg_i` and a non-zero `win_peer_i`. A zero peer size means no limit. The result is clamped to the range 1 to DEPTH-1.
- R11: At most one handle is released per cycle. While `rel_ready_i` is low, `rel_valid_o` and `rel_hdl_o` hold. `cmd_ready_o` is low while a command is being processed, and a frame has priority over a request presented in the same cycle.
- R12: `sess_start_i` empties the buffer, aborts any command in progress and loads the expected sequence from `ssn_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| agg_en_i | input | 1 | Aggregation session established |
| win_cfg_i | input | WIN_W | Locally configured window size |
| win_peer_i | input | WIN_W | Peer-negotiated window size, 0 = no limit |
| sess_start_i | input | 1 | Session start pulse |
| ssn_i | input | 12 | Starting sequence for session start |
| seq_rst_i | input | 1 | Request resynchronisation on next frame |
| frm_valid_i | input | 1 | Frame present |
| frm_seq_i | input | 12 | Frame sequence number |
| frm_hdl_i | input | HDL_W | Frame buffer handle |
| bar_valid_i | input | 1 | Block-ack request present |
| bar_seq_i | input | 12 | Request start sequence |
| cmd_ready_o | output | 1 | Frame or request accepted this cycle when valid |
| tick_i | input | 1 | Timeout tick pulse |
| rel_valid_o | output | 1 | Released handle valid |
| rel_hdl_o | output | HDL_W | Released handle |
| rel_ready_i | input | 1 | Upstream accepts the released handle |
| drop_o | output | 1 | Old frame or stale request discarded |
| dup_o | output | 1 | Duplicate frame discarded |

## Verification
Properties checked on every cycle cover the following. The release stream holds under backpressure. No command is accepted while a release is pending. Each in-order release moves the expected sequence by exactly one. A slot is never written while occupied. An empty window never shows a held head slot. Drop and duplicate never pulse together, and session start clears the release stream. Sequence-order recovery after gaps, wraparound at 4096, forced head advance, request-driven release, the old-frame limit, window minimum selection and age-based timeout all depend on multi-command histories. These are shown only by the bench scenarios, which compare release counts and last handles against values worked out from the requirements.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int SEQ_W = 12;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BYP,
    S_ADV,
    S_INS,
    S_DRAIN,
    S_BAR,
    S_TMO
  } rob_state_e;
endpackage

// File: rtl/rob_win_calc.sv
module rob_win_calc
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int WIN_W = $clog2(DEPTH) + 1
) (
  input  logic [WIN_W-1:0] win_cfg_i,
  input  logic [WIN_W-1:0] win_peer_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [SEQ_W-1:0] exp_i,
  output logic [WIN_W-1:0] win_o,
  output logic [SEQ_W-1:0] idx_o,
  output logic             old_o,
  output logic             beyond_o,
  output logic             bar_stale_o
);
  localparam logic [SEQ_W:0] SEQ_SPAN = {1'b1, {SEQ_W{1'b0}}};

  logic [WIN_W-1:0] w;
  logic [SEQ_W:0]   lim;

  always_comb begin
    w = win_cfg_i;
    if (win_peer_i != '0 && win_peer_i < w) w = win_peer_i;
    if (w > WIN_W'(DEPTH - 1)) w = WIN_W'(DEPTH - 1);
    if (w == '0) w = WIN_W'(1);
  end

  assign win_o       = w;
  assign idx_o       = seq_i - exp_i;
  assign lim         = SEQ_SPAN - ((SEQ_W + 1)'(w) << 2);
  assign old_o       = {1'b0, idx_o} > lim;
  assign beyond_o    = idx_o >= SEQ_W'(w);
  assign bar_stale_o = old_o && (idx_o > SEQ_W'(w));

  // R10: effective window never exceeds either non-zero source
  always_comb begin
    a_r10_win_min: assert (win_o <= win_cfg_i || win_cfg_i == '0 || win_cfg_i > WIN_W'(DEPTH - 1));
  end
endmodule

// File: rtl/rob_slot_store.sv
module rob_slot_store #(
  parameter int DEPTH = 16,
  parameter int HDL_W = 8,
  parameter int TS_W  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [HDL_W-1:0] wr_hdl_i,
  input  logic [TS_W-1:0]  wr_ts_i,
  input  logic             kill_i,
  input  logic [PTR_W-1:0] kill_idx_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic             rd_vld_o,
  output logic [HDL_W-1:0] rd_hdl_o,
  output logic [TS_W-1:0]  rd_ts_o,
  input  logic [PTR_W-1:0] chk_idx_i,
  output logic             chk_vld_o
);
  logic [DEPTH-1:0] vld_q;
  logic [HDL_W-1:0] hdl_q [DEPTH];
  logic [TS_W-1:0]  ts_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_i && wr_idx_i == PTR_W'(i))          vld_q[i] <= 1'b1;
        else if (kill_i && kill_idx_i == PTR_W'(i)) vld_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_i && wr_idx_i == PTR_W'(i)) begin
        hdl_q[i] <= wr_hdl_i;
        ts_q[i]  <= wr_ts_i;
      end
    end
  end

  assign rd_vld_o  = vld_q[rd_idx_i];
  assign rd_hdl_o  = hdl_q[rd_idx_i];
  assign rd_ts_o   = ts_q[rd_idx_i];
  assign chk_vld_o = vld_q[chk_idx_i];

  // R5: an occupied slot is never overwritten
  a_r5_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |-> !vld_q[wr_idx_i]);
endmodule

// File: rtl/ba_reorder_buf.sv
module ba_reorder_buf
  import rob_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int HDL_W   = 8,
  parameter int TS_W    = 16,
  parameter int TMO_CYC = 64,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int WIN_W  = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             agg_en_i,
  input  logic [WIN_W-1:0] win_cfg_i,
  input  logic [WIN_W-1:0] win_peer_i,
  input  logic             sess_start_i,
  input  logic [SEQ_W-1:0] ssn_i,
  input  logic             seq_rst_i,
  input  logic             frm_valid_i,
  input  logic [SEQ_W-1:0] frm_seq_i,
  input  logic [HDL_W-1:0] frm_hdl_i,
  input  logic             bar_valid_i,
  input  logic [SEQ_W-1:0] bar_seq_i,
  output logic             cmd_ready_o,
  input  logic             tick_i,
  output logic             rel_valid_o,
  output logic [HDL_W-1:0] rel_hdl_o,
  input  logic             rel_ready_i,
  output logic             drop_o,
  output logic             dup_o
);
  rob_state_e       state_q;
  logic [PTR_W-1:0] head_q, tail_q;
  logic [SEQ_W-1:0] seq_next_q, p_seq_q;
  logic [HDL_W-1:0] p_hdl_q;
  logic [TS_W-1:0]  now_q;
  logic             seq_rst_q, tmo_pend_q, drop_q, dup_q;

  logic             idle, empty, rel_v, step, aged;
  logic [SEQ_W-1:0] seq_sel, exp_sel, idx;
  logic [WIN_W-1:0] win;
  logic             old, beyond, bar_stale;
  logic [PTR_W-1:0] slot, occ;
  logic             head_vld, slot_vld, wr;
  logic [HDL_W-1:0] head_hdl;
  logic [TS_W-1:0]  head_ts;

  assign idle    = (state_q == S_IDLE);
  assign empty   = (head_q == tail_q);
  assign occ     = tail_q - head_q;
  assign seq_sel = idle ? (frm_valid_i ? frm_seq_i : bar_seq_i) : p_seq_q;
  assign exp_sel = (idle && frm_valid_i && seq_rst_q) ? frm_seq_i : seq_next_q;
  assign slot    = head_q + idx[PTR_W-1:0];
  assign aged    = (now_q - head_ts) >= TS_W'(TMO_CYC);
  assign wr      = (state_q == S_INS) && !slot_vld && !sess_start_i;

  rob_win_calc #(.DEPTH(DEPTH)) u_win (
    .win_cfg_i  (win_cfg_i),
    .win_peer_i (win_peer_i),
    .seq_i      (seq_sel),
    .exp_i      (exp_sel),
    .win_o      (win),
    .idx_o      (idx),
    .old_o      (old),
    .beyond_o   (beyond),
    .bar_stale_o(bar_stale)
  );

  rob_slot_store #(.DEPTH(DEPTH), .HDL_W(HDL_W), .TS_W(TS_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sess_start_i),
    .wr_i      (wr),
    .wr_idx_i  (slot),
    .wr_hdl_i  (p_hdl_q),
    .wr_ts_i   (now_q),
    .kill_i    (step && head_vld),
    .kill_idx_i(head_q),
    .rd_idx_i  (head_q),
    .rd_vld_o  (head_vld),
    .rd_hdl_o  (head_hdl),
    .rd_ts_o   (head_ts),
    .chk_idx_i (slot),
    .chk_vld_o (slot_vld)
  );

  // step: head and expected sequence move by one (release or skip)
  always_comb begin
    rel_v = 1'b0;
    step  = 1'b0;
    unique case (state_q)
      S_BYP: rel_v = 1'b1;
      S_ADV: if (beyond && !empty) begin
        rel_v = head_vld;
        step  = !head_vld || rel_ready_i;
      end
      S_DRAIN: if (!empty && head_vld) begin
        rel_v = 1'b1;
        step  = rel_ready_i;
      end
      S_BAR: if (!empty && idx != '0) begin
        rel_v = head_vld;
        step  = !head_vld || rel_ready_i;
      end
      S_TMO: if (!empty && (!head_vld || aged)) begin
        rel_v = head_vld;
        step  = !head_vld || rel_ready_i;
      end
      default: ;
    endcase
  end

  assign rel_valid_o = rel_v;
  assign rel_hdl_o   = (state_q == S_BYP) ? p_hdl_q : head_hdl;
  assign cmd_ready_o = idle;
  assign drop_o      = drop_q;
  assign dup_o       = dup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      head_q     <= '0;
      tail_q     <= '0;
      seq_next_q <= '0;
      p_seq_q    <= '0;
      p_hdl_q    <= '0;
      now_q      <= '0;
      seq_rst_q  <= 1'b0;
      tmo_pend_q <= 1'b0;
      drop_q     <= 1'b0;
      dup_q      <= 1'b0;
    end else begin
      now_q  <= now_q + TS_W'(1);
      drop_q <= 1'b0;
      dup_q  <= 1'b0;
      if (sess_start_i) begin
        state_q    <= S_IDLE;
        head_q     <= '0;
        tail_q     <= '0;
        seq_next_q <= ssn_i;
        seq_rst_q  <= 1'b0;
        tmo_pend_q <= 1'b0;
      end else begin
        if (seq_rst_i) seq_rst_q <= 1'b1;
        if (step) begin
          head_q     <= head_q + PTR_W'(1);
          seq_next_q <= seq_next_q + SEQ_W'(1);
        end
        unique case (state_q)
          S_IDLE: begin
            if (frm_valid_i) begin
              p_hdl_q <= frm_hdl_i;
              if (!agg_en_i) begin
                state_q <= S_BYP;
              end else begin
                if (seq_rst_q) begin
                  seq_next_q <= frm_seq_i;
                  seq_rst_q  <= 1'b0;
                end
                if (old) drop_q <= 1'b1;
                else begin
                  p_seq_q <= frm_seq_i;
                  state_q <= S_ADV;
                end
              end
            end else if (bar_valid_i) begin
              if (!agg_en_i || bar_stale) drop_q <= 1'b1;
              else begin
                p_seq_q <= bar_seq_i;
                state_q <= S_BAR;
              end
            end else if (tmo_pend_q) begin
              tmo_pend_q <= 1'b0;
              state_q    <= S_TMO;
            end
          end
          S_BYP: if (rel_ready_i) state_q <= S_IDLE;
          S_ADV: begin
            if (!beyond) state_q <= S_INS;
            else if (empty) seq_next_q <= p_seq_q - SEQ_W'(win) + SEQ_W'(1);
          end
          S_INS: begin
            if (slot_vld) begin
              dup_q   <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              if (idx >= SEQ_W'(occ)) tail_q <= slot + PTR_W'(1);
              state_q <= S_DRAIN;
            end
          end
          S_DRAIN: if (empty || !head_vld) state_q <= S_IDLE;
          S_BAR: if (empty || idx == '0) begin
            if (empty && idx != '0) seq_next_q <= p_seq_q;
            state_q <= S_DRAIN;
          end
          S_TMO: if (empty || (head_vld && !aged)) state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
        if (tick_i) tmo_pend_q <= 1'b1;
      end
    end
  end

  // R11: release stream holds under backpressure
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || sess_start_i)
    (rel_valid_o && !rel_ready_i) |=> (rel_valid_o && $stable(rel_hdl_o)));
  // R11: no command accepted while a release is offered
  a_r11_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !rel_valid_o);
  // R2: each buffered release moves expected sequence by one
  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni || sess_start_i)
    (rel_valid_o && rel_ready_i && state_q != S_BYP) |=> (seq_next_q == $past(seq_next_q) + SEQ_W'(1)));
  // R3: an empty window never shows a held head slot
  a_r3_empty_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !head_vld);
  // R4: drop and duplicate are exclusive
  a_r4_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drop_o && dup_o));
  // R12: session start leaves nothing on the release stream
  a_r12_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_start_i |=> !rel_valid_o);
endmodule

// File: tb/ba_reorder_buf_bench.sv
`timescale 1ns/1ps
module ba_reorder_buf_bench;
  localparam int DEPTH = 16;
  localparam int HDL_W = 8;
  localparam int TMO   = 64;
  localparam int WIN_W = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic agg_en = 1'b0, sess_start = 1'b0, seq_rst = 1'b0;
  logic [WIN_W-1:0] win_cfg = 5'd8, win_peer = '0;
  logic [11:0] ssn = '0, frm_seq = '0, bar_seq = '0;
  logic frm_valid = 1'b0, bar_valid = 1'b0, tick = 1'b0, rel_ready = 1'b1;
  logic [HDL_W-1:0] frm_hdl = '0;
  logic cmd_ready, rel_valid, drop, dup;
  logic [HDL_W-1:0] rel_hdl;

  int n_chk = 0, n_fail = 0, rel_cnt = 0;
  logic [HDL_W-1:0] last_hdl = '0;
  logic drop_seen = 1'b0, dup_seen = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ba_reorder_buf #(.DEPTH(DEPTH), .HDL_W(HDL_W), .TMO_CYC(TMO)) u_ba_reorder_buf (
    .clk_i(clk), .rst_ni(rst_ni), .agg_en_i(agg_en), .win_cfg_i(win_cfg),
    .win_peer_i(win_peer), .sess_start_i(sess_start), .ssn_i(ssn), .seq_rst_i(seq_rst),
    .frm_valid_i(frm_valid), .frm_seq_i(frm_seq), .frm_hdl_i(frm_hdl),
    .bar_valid_i(bar_valid), .bar_seq_i(bar_seq), .cmd_ready_o(cmd_ready),
    .tick_i(tick), .rel_valid_o(rel_valid), .rel_hdl_o(rel_hdl),
    .rel_ready_i(rel_ready), .drop_o(drop), .dup_o(dup)
  );

  always @(negedge clk) begin
    if (rel_valid && rel_ready) begin
      rel_cnt++;
      last_hdl = rel_hdl;
    end
    if (drop) drop_seen = 1'b1;
    if (dup) dup_seen = 1'b1;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_cmd(bit is_bar, int seq, int hdl);
    @(posedge clk); #1;
    drop_seen = 1'b0; dup_seen = 1'b0;
    if (is_bar) begin bar_valid = 1'b1; bar_seq = 12'(seq); end
    else begin frm_valid = 1'b1; frm_seq = 12'(seq); frm_hdl = HDL_W'(hdl); end
    @(posedge clk); #1;
    frm_valid = 1'b0; bar_valid = 1'b0;
    settle();
  endtask

  task automatic do_tick();
    @(posedge clk); #1 tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
    settle();
  endtask

  task automatic start_sess(int s);
    @(posedge clk); #1 sess_start = 1'b1; ssn = 12'(s);
    @(posedge clk); #1 sess_start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        bar;
    logic [11:0] seq;
    logic [7:0]  hdl;
    logic [7:0]  tot;
    logic [7:0]  last;
    logic        drp;
    logic        dp;
  } vec_t;

  // window 8, session starts at 100
  localparam vec_t TAB [17] = '{
    '{4'd2, 1'b0, 12'd100,  8'd1,  8'd1,  8'd1,  1'b0, 1'b0}, // R2 in order
    '{4'd3, 1'b0, 12'd102,  8'd2,  8'd1,  8'd1,  1'b0, 1'b0}, // R3 held
    '{4'd3, 1'b0, 12'd103,  8'd3,  8'd1,  8'd1,  1'b0, 1'b0},
    '{4'd3, 1'b0, 12'd101,  8'd4,  8'd4,  8'd3,  1'b0, 1'b0}, // gap closes
    '{4'd4, 1'b0, 12'd102,  8'd5,  8'd4,  8'd3,  1'b1, 1'b0}, // R4 old
    '{4'd3, 1'b0, 12'd106,  8'd6,  8'd4,  8'd3,  1'b0, 1'b0},
    '{4'd5, 1'b0, 12'd106,  8'd7,  8'd4,  8'd3,  1'b0, 1'b1}, // R5 dup
    '{4'd6, 1'b0, 12'd113,  8'd8,  8'd5,  8'd6,  1'b0, 1'b0}, // R6 beyond
    '{4'd8, 1'b1, 12'd110,  8'd0,  8'd5,  8'd6,  1'b0, 1'b0}, // R8 skip empties
    '{4'd3, 1'b0, 12'd111,  8'd10, 8'd5,  8'd6,  1'b0, 1'b0},
    '{4'd3, 1'b0, 12'd110,  8'd11, 8'd7,  8'd10, 1'b0, 1'b0},
    '{4'd8, 1'b1, 12'd114,  8'd0,  8'd8,  8'd8,  1'b0, 1'b0}, // R8 releases held
    '{4'd8, 1'b1, 12'd4094, 8'd0,  8'd8,  8'd8,  1'b0, 1'b0}, // R8 empty jump
    '{4'd3, 1'b0, 12'd4095, 8'd14, 8'd8,  8'd8,  1'b0, 1'b0},
    '{4'd3, 1'b0, 12'd4094, 8'd15, 8'd10, 8'd14, 1'b0, 1'b0}, // wrap
    '{4'd2, 1'b0, 12'd0,    8'd16, 8'd11, 8'd16, 1'b0, 1'b0},
    '{4'd8, 1'b1, 12'd4090, 8'd0,  8'd11, 8'd16, 1'b1, 1'b0}  // R8 stale
  };

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk); #1;
    check("R11 reset rel_valid", int'(rel_valid), 0);
    check("R11 reset cmd_ready", int'(cmd_ready), 1);
    check("R4 reset drop", int'(drop), 0);
    check("R5 reset dup", int'(dup), 0);

    agg_en = 1'b1;
    start_sess(100);
    for (int i = 0; i < 17; i++) begin
      do_cmd(TAB[i].bar, int'(TAB[i].seq), int'(TAB[i].hdl));
      check($sformatf("R%0d tbl%0d count", TAB[i].req, i), rel_cnt, int'(TAB[i].tot));
      check($sformatf("R%0d tbl%0d last", TAB[i].req, i), int'(last_hdl), int'(TAB[i].last));
      check($sformatf("R%0d tbl%0d drop", TAB[i].req, i), int'(drop_seen), int'(TAB[i].drp));
      check($sformatf("R%0d tbl%0d dup", TAB[i].req, i), int'(dup_seen), int'(TAB[i].dp));
    end

    // R9 timeout: far frame parked behind seven empty slots
    do_cmd(1'b0, 500, 20);
    check("R6 far frame held", rel_cnt, 11);
    do_tick();
    check("R9 young frame kept", rel_cnt, 11);
    repeat (TMO + 10) @(posedge clk);
    do_tick();
    check("R9 aged released", rel_cnt, 12);
    check("R9 aged handle", int'(last_hdl), 20);
    do_cmd(1'b0, 502, 21);
    repeat (TMO + 5) @(posedge clk);
    do_cmd(1'b0, 504, 22);
    do_tick();
    check("R9 stop at recent count", rel_cnt, 13);
    check("R9 stop at recent handle", int'(last_hdl), 21);
    repeat (TMO + 5) @(posedge clk);
    do_tick();
    check("R9 second flush", int'(last_hdl), 22);

    // R10: peer window 4 forces the head forward
    win_peer = 5'd4;
    do_cmd(1'b0, 506, 23);
    check("R10 held", rel_cnt, 14);
    do_cmd(1'b0, 509, 24);
    check("R10 min window count", rel_cnt, 15);
    check("R10 min window handle", int'(last_hdl), 23);
    win_peer = '0;

    // R12 + R11: new session, backpressure
    start_sess(50);
    @(posedge clk); #1 rel_ready = 1'b0; frm_valid = 1'b1; frm_seq = 12'd50; frm_hdl = 8'd30;
    @(posedge clk); #1 frm_valid = 1'b0;
    repeat (4) @(negedge clk); #1;
    check("R11 valid under stall", int'(rel_valid), 1);
    check("R12 ssn loaded", int'(rel_hdl), 30);
    check("R11 busy", int'(cmd_ready), 0);
    @(negedge clk); #1;
    check("R11 handle stable", int'(rel_hdl), 30);
    check("R11 no release while stalled", rel_cnt, 15);
    @(posedge clk); #1 rel_ready = 1'b1;
    settle();
    check("R11 released after ready", rel_cnt, 16);
    check("R12 old session frame dropped from buffer", int'(last_hdl), 30);

    // R7 resync
    @(posedge clk); #1 seq_rst = 1'b1;
    @(posedge clk); #1 seq_rst = 1'b0;
    do_cmd(1'b0, 2000, 31);
    check("R7 resync count", rel_cnt, 17);
    check("R7 resync handle", int'(last_hdl), 31);
    do_cmd(1'b0, 2001, 32);
    check("R7 follow-on", rel_cnt, 18);

    // R1 bypass
    agg_en = 1'b0;
    do_cmd(1'b0, 7, 33);
    check("R1 bypass count", rel_cnt, 19);
    check("R1 bypass handle", int'(last_hdl), 33);
    do_cmd(1'b0, 3, 34);
    check("R1 bypass out of order", int'(last_hdl), 34);
    do_cmd(1'b1, 5, 0);
    check("R8 request without session dropped", int'(drop_seen), 1);
    check("R8 request without session no release", rel_cnt, 20);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule